// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block arbitrates every reset source of a clock-generator control core. Four sources are handled: a power-on pulse, an active-low reset pin that can go low at any moment, a software reset made of two request bits in the block's own 8-bit control register, and a separate self-clearing request that forces a reload from nonvolatile storage. Each source holds the rest of the core in reset through `core_rst`. When the source lets go, the block issues a one-cycle configuration load request and indicates whether the loader should use stored settings or built-in defaults.

The block then keeps the clock outputs static until a wait expires. The length of that wait depends on the source that fired and on the storage-select pin. Power-on and pin resets also keep a sync request raised, so that the dividers come out of the wait phase-aligned. If a new source fires during a wait, the whole sequence starts again. All waits are counted in system clock cycles and set by parameters.

Top module: `rst_sequencer`

## Requirements
- R1: `cfg_from_nv`, valid while `cfg_load` is high, equals `store_sel` for power-on, pin and software resets, and is 1 after a forced storage reload.
- R2: While `por` is high, `core_rst`=1, `outputs_en`=0, `sync_req`=1 and `ctrl_q`=0. After `por` falls, `cfg_load` pulses for exactly one cycle, and `outputs_en` rises exactly POR_CYC cycles after `cfg_load` rises.
- R3: A low level on `rst_pin_n` seen at a rising clock edge sets `core_rst` and clears `ctrl_q` at that same edge. Release passes through a two-stage synchronizer, so `cfg_load` rises at the third rising edge after the pin returns high.
- R4: After a pin reset, `outputs_en` rises FAST_CYC cycles after `cfg_load` when `store_sel`=0, and NV_CYC cycles after it when `store_sel`=1. `sync_req` stays at 1 throughout that wait.
- R5: Writing `ctrl_q` with bit 2 and bit 5 both at 1 raises `core_rst` at the next edge. After release, the wait is FAST_CYC when `store_sel`=0 and NV_CYC when `store_sel`=1.
- R6: During a software reset, every `ctrl_q` bit other than 2 and 5 keeps the value that was written. A write with only one of bits 2 or 5 set is stored as written and starts no reset.
- R7: Bits 2 and 5 clear only on a `sclk_tick` that comes in a cycle after the write. `core_rst` stays at 1 until they have cleared.
- R8: A write of 1 to the forced-reload bit (`nvf_wr` with `nvf_wdata`=1) sets `nvf_q` and holds the core in reset only when `store_sel`=0. With `store_sel`=1 it is ignored. The bit clears on the next `sclk_tick`, and `outputs_en` then rises NV_CYC cycles after `cfg_load`.
- R9: `outputs_en` is 0 whenever `core_rst` is 1 or a wait is running. `sync_req` is 0 while outputs run, and it is never raised for software or forced-reload resets.
- R10: A source that fires during a wait sets `core_rst` again at the next edge and restarts the sequence. `outputs_en` stays at 0 until the full wait measured from the new `cfg_load` has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on pulse, synchronous, active high |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| store_sel | input | 1 | 1 = restore from nonvolatile storage, 0 = built-in defaults |
| sclk_tick | input | 1 | One-cycle strobe marking a completed serial clock cycle |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | REG_W | Control register write data |
| nvf_wr | input | 1 | Write strobe for the forced-reload bit |
| nvf_wdata | input | 1 | Forced-reload bit write data |
| ctrl_q | output | REG_W | Control register contents |
| nvf_q | output | 1 | Forced-reload bit contents |
| core_rst | output | 1 | Reset to the rest of the core, active high |
| cfg_load | output | 1 | One-cycle configuration load request |
| cfg_from_nv | output | 1 | Load source for the loader: 1 = storage |
| sync_req | output | 1 | Divider phase-alignment request |
| outputs_en | output | 1 | Clock outputs may toggle |

## Verification
The assertions check the following relations on every cycle:
- outputs are blocked while `core_rst` is high;
- the pin takes effect at once;
- the software request and the forced-reload bit hold the core in reset;
- bits 2 and 5 self-clear on a tick;
- the other control bits are preserved;
- the forced-reload bit is ignored when storage is selected;
- `cfg_load` lasts a single cycle;
- `sync_req` is low while outputs run.

Only the bench scenarios can show the exact wait lengths for each source and pin setting, the three-edge release latency of the pin, the load source reported for each case, and the full restart when a reset arrives in the middle of a wait.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_POR,
        SRC_PIN,
        SRC_SWR,
        SRC_NVF
    } rst_src_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_WAIT,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic pin;
        logic swr;
        logic nvf;
    } req_vec_t;

    // Fixed priority: pin, then software request, then forced reload.
    function automatic rst_src_e pick_src(input req_vec_t r);
        if (r.pin)      return SRC_PIN;
        else if (r.swr) return SRC_SWR;
        else if (r.nvf) return SRC_NVF;
        else            return SRC_NONE;
    endfunction

    function automatic logic any_req(input req_vec_t r);
        return r.pin | r.swr | r.nvf;
    endfunction

    function automatic logic uses_store(input rst_src_e s, input logic store_sel);
        return (s == SRC_NVF) ? 1'b1 : store_sel;
    endfunction

    function automatic logic wants_sync(input rst_src_e s);
        return (s == SRC_POR) || (s == SRC_PIN);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rsq_pin_sync.sv
`timescale 1ns/1ps
module rsq_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_pin_n,
    output logic pin_req
);
    logic [STAGES-1:0] sh;

    // Assertion is immediate (asynchronous clear); release walks through STAGES flops.
    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) sh <= '0;
        else            sh <= {sh[STAGES-2:0], 1'b1};
    end

    assign pin_req = ~sh[STAGES-1];
endmodule

// File: rtl/rsq_ctrl_regs.sv
`timescale 1ns/1ps
module rsq_ctrl_regs #(
    parameter int unsigned REG_W = 8,
    parameter int unsigned BIT_A = 2,
    parameter int unsigned BIT_B = 5
) (
    input  logic             clk,
    input  logic             por,
    input  logic             pin_req,
    input  logic             wr_allow,
    input  logic             store_sel,
    input  logic             sclk_tick,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             nvf_wr,
    input  logic             nvf_wdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic             nvf_q,
    output logic             swr_req
);
    logic [REG_W-1:0] ctrl_r;
    logic             nvf_r;
    logic             wr_ok;

    assign swr_req = ctrl_r[BIT_A] & ctrl_r[BIT_B];
    assign wr_ok   = wr_allow & ~swr_req & ~nvf_r;

    always_ff @(posedge clk) begin
        if (por || pin_req) begin
            ctrl_r <= '0;
            nvf_r  <= 1'b0;
        end else begin
            // Software request: both bits drop on a later serial tick, the rest is kept.
            if (swr_req) begin
                if (sclk_tick) begin
                    ctrl_r[BIT_A] <= 1'b0;
                    ctrl_r[BIT_B] <= 1'b0;
                end
            end else if (ctrl_wr && wr_ok) begin
                ctrl_r <= ctrl_wdata;
            end

            // Forced reload: accepted only when defaults are selected.
            if (nvf_r) begin
                if (sclk_tick) nvf_r <= 1'b0;
            end else if (nvf_wr && wr_ok && !store_sel) begin
                nvf_r <= nvf_wdata;
            end
        end
    end

    assign ctrl_q = ctrl_r;
    assign nvf_q  = nvf_r;
endmodule

// File: rtl/rsq_wait_timer.sv
`timescale 1ns/1ps
module rsq_wait_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/rsq_seq_fsm.sv
`timescale 1ns/1ps
module rsq_seq_fsm
    import rsq_pkg::*;
#(
    parameter int unsigned POR_CYC  = 64,
    parameter int unsigned FAST_CYC = 16,
    parameter int unsigned NV_CYC   = 32,
    parameter int unsigned CNT_W    = 8
) (
    input  logic             clk,
    input  logic             por,
    input  req_vec_t         req,
    input  logic             store_sel,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_run,
    output logic             core_rst,
    output logic             outputs_en,
    output logic             sync_req,
    output logic             cfg_load,
    output logic             cfg_from_nv
);
    seq_state_e state;
    rst_src_e   src;
    logic       load_q;
    logic       from_nv_q;
    logic       req_any;

    assign req_any = any_req(req);

    always_ff @(posedge clk) begin
        if (por) begin
            state     <= ST_HOLD;
            src       <= SRC_POR;
            load_q    <= 1'b0;
            from_nv_q <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (req_any) begin
                state <= ST_HOLD;
                src   <= pick_src(req);
            end else begin
                unique case (state)
                    ST_HOLD: begin
                        state     <= ST_WAIT;
                        load_q    <= 1'b1;
                        from_nv_q <= uses_store(src, store_sel);
                    end
                    ST_WAIT: if (tmr_done) state <= ST_RUN;
                    default: ;
                endcase
            end
        end
    end

    // Wait length loaded as count-1 so the run state begins exactly N edges after release.
    always_comb begin
        if (src == SRC_POR)                 tmr_val = CNT_W'(POR_CYC - 1);
        else if (uses_store(src, store_sel)) tmr_val = CNT_W'(NV_CYC - 1);
        else                                tmr_val = CNT_W'(FAST_CYC - 1);
    end

    assign tmr_load    = (state == ST_HOLD) && !req_any;
    assign tmr_run     = (state == ST_WAIT);
    assign core_rst    = (state == ST_HOLD);
    assign outputs_en  = (state == ST_RUN);
    assign sync_req    = (state != ST_RUN) && wants_sync(src);
    assign cfg_load    = load_q;
    assign cfg_from_nv = from_nv_q;
endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
module rst_sequencer
    import rsq_pkg::*;
#(
    parameter int unsigned POR_CYC     = 8750000,
    parameter int unsigned FAST_CYC    = 250,
    parameter int unsigned NV_CYC      = 5000000,
    parameter int unsigned REG_W       = 8,
    parameter int unsigned SWR_BIT_A   = 2,
    parameter int unsigned SWR_BIT_B   = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst_pin_n,
    input  logic             store_sel,
    input  logic             sclk_tick,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             nvf_wr,
    input  logic             nvf_wdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic             nvf_q,
    output logic             core_rst,
    output logic             cfg_load,
    output logic             cfg_from_nv,
    output logic             sync_req,
    output logic             outputs_en
);
    localparam int unsigned MAX_CYC = max3(POR_CYC, FAST_CYC, NV_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic             pin_req;
    logic             swr_req;
    logic             tmr_load;
    logic             tmr_run;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;
    req_vec_t         req;

    rsq_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk       (clk),
        .rst_pin_n (rst_pin_n),
        .pin_req   (pin_req)
    );

    rsq_ctrl_regs #(.REG_W(REG_W), .BIT_A(SWR_BIT_A), .BIT_B(SWR_BIT_B)) u_regs (
        .clk        (clk),
        .por        (por),
        .pin_req    (pin_req),
        .wr_allow   (~core_rst),
        .store_sel  (store_sel),
        .sclk_tick  (sclk_tick),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .nvf_wr     (nvf_wr),
        .nvf_wdata  (nvf_wdata),
        .ctrl_q     (ctrl_q),
        .nvf_q      (nvf_q),
        .swr_req    (swr_req)
    );

    assign req.pin = pin_req;
    assign req.swr = swr_req;
    assign req.nvf = nvf_q;

    rsq_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (por),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .done     (tmr_done)
    );

    rsq_seq_fsm #(
        .POR_CYC  (POR_CYC),
        .FAST_CYC (FAST_CYC),
        .NV_CYC   (NV_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .por         (por),
        .req         (req),
        .store_sel   (store_sel),
        .tmr_done    (tmr_done),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_run     (tmr_run),
        .core_rst    (core_rst),
        .outputs_en  (outputs_en),
        .sync_req    (sync_req),
        .cfg_load    (cfg_load),
        .cfg_from_nv (cfg_from_nv)
    );
endmodule

// File: rtl/rst_sequencer_chk.sv
`timescale 1ns/1ps
module rst_sequencer_chk #(
    parameter int unsigned REG_W     = 8,
    parameter int unsigned SWR_BIT_A = 2,
    parameter int unsigned SWR_BIT_B = 5
) (
    input logic             clk,
    input logic             por,
    input logic             store_sel,
    input logic             sclk_tick,
    input logic             pin_req,
    input logic             swr_req,
    input logic [REG_W-1:0] ctrl_q,
    input logic             nvf_q,
    input logic             core_rst,
    input logic             cfg_load,
    input logic             sync_req,
    input logic             outputs_en
);
    localparam logic [REG_W-1:0] SW_MASK =
        (REG_W'(1) << SWR_BIT_A) | (REG_W'(1) << SWR_BIT_B);

    p_static_in_reset_r9: assert property (@(posedge clk) disable iff (por)
        core_rst |-> !outputs_en);

    p_sync_off_when_running_r9: assert property (@(posedge clk) disable iff (por)
        outputs_en |-> !sync_req);

    p_pin_immediate_r3: assert property (@(posedge clk) disable iff (por)
        pin_req |=> (core_rst && ctrl_q == '0));

    p_swr_holds_r7: assert property (@(posedge clk) disable iff (por)
        swr_req |=> core_rst);

    p_selfclear_r7: assert property (@(posedge clk) disable iff (por)
        (swr_req && sclk_tick) |=> ((ctrl_q & SW_MASK) == '0));

    p_keep_bits_r6: assert property (@(posedge clk) disable iff (por)
        (swr_req && !pin_req) |=> $stable(ctrl_q & ~SW_MASK));

    p_nvf_ignored_r8: assert property (@(posedge clk) disable iff (por)
        (store_sel && !nvf_q) |=> !nvf_q);

    p_nvf_holds_r8: assert property (@(posedge clk) disable iff (por)
        nvf_q |=> core_rst);

    p_load_single_r2: assert property (@(posedge clk) disable iff (por)
        cfg_load |=> !cfg_load);
endmodule

bind rst_sequencer rst_sequencer_chk #(
    .REG_W     (REG_W),
    .SWR_BIT_A (SWR_BIT_A),
    .SWR_BIT_B (SWR_BIT_B)
) u_chk (
    .clk        (clk),
    .por        (por),
    .store_sel  (store_sel),
    .sclk_tick  (sclk_tick),
    .pin_req    (pin_req),
    .swr_req    (swr_req),
    .ctrl_q     (ctrl_q),
    .nvf_q      (nvf_q),
    .core_rst   (core_rst),
    .cfg_load   (cfg_load),
    .sync_req   (sync_req),
    .outputs_en (outputs_en)
);

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;
    localparam int unsigned TP = 40;
    localparam int unsigned TF = 12;
    localparam int unsigned TN = 30;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst_pin_n = 1'b1;
    logic       store_sel = 1'b0;
    logic       sclk_tick = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       nvf_wr = 1'b0;
    logic       nvf_wdata = 1'b0;
    logic [7:0] ctrl_q;
    logic       nvf_q, core_rst, cfg_load, cfg_from_nv, sync_req, outputs_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rst_sequencer #(.POR_CYC(TP), .FAST_CYC(TF), .NV_CYC(TN)) u_rst_sequencer (
        .clk(clk), .por(por), .rst_pin_n(rst_pin_n), .store_sel(store_sel),
        .sclk_tick(sclk_tick), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .nvf_wr(nvf_wr), .nvf_wdata(nvf_wdata), .ctrl_q(ctrl_q), .nvf_q(nvf_q),
        .core_rst(core_rst), .cfg_load(cfg_load), .cfg_from_nv(cfg_from_nv),
        .sync_req(sync_req), .outputs_en(outputs_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        ctrl_wr = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_nvf(input logic d);
        nvf_wr = 1'b1; nvf_wdata = d;
        @(negedge clk);
        nvf_wr = 1'b0;
    endtask

    task automatic tick();
        sclk_tick = 1'b1;
        @(negedge clk);
        sclk_tick = 1'b0;
    endtask

    task automatic await_load(input string tag);
        int n = 0;
        while (!cfg_load && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(cfg_load === 1'b1, tag, int'(cfg_load), 1);
    endtask

    // Called at the sample where cfg_load is high; counts cycles until outputs run.
    task automatic time_resume(input int exp, input string tag, input bit exp_sync);
        int n = 0;
        bit sync_ok = 1'b1;
        while (!outputs_en && n < 2000) begin
            if (sync_req !== exp_sync) sync_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n == exp, {tag, " wait length"}, n, exp);
        chk(sync_ok, {tag, " sync_req during wait"}, int'(sync_ok), 1);
        chk(sync_req === 1'b0, "R9 sync_req low once running", int'(sync_req), 0);
    endtask

    task automatic t_reset_state();
        step(3);
        chk(core_rst === 1'b1, "R2 core_rst in power-on", int'(core_rst), 1);
        chk(outputs_en === 1'b0, "R2 outputs_en in power-on", int'(outputs_en), 0);
        chk(sync_req === 1'b1, "R2 sync_req in power-on", int'(sync_req), 1);
        chk(ctrl_q === 8'h00, "R2 ctrl_q in power-on", int'(ctrl_q), 0);
    endtask

    task automatic t_por_release();
        store_sel = 1'b0;
        por = 1'b0;
        await_load("R2 load after power-on");
        chk(cfg_from_nv === 1'b0, "R1 power-on source", int'(cfg_from_nv), 0);
        time_resume(TP, "R2", 1'b1);
    endtask

    task automatic t_pin(input logic sel, input int exp);
        store_sel = sel;
        wr_ctrl(8'h41);
        chk(ctrl_q === 8'h41, "R6 plain write stored", int'(ctrl_q), 'h41);
        chk(core_rst === 1'b0, "R6 plain write no reset", int'(core_rst), 0);
        rst_pin_n = 1'b0;
        @(negedge clk);
        chk(core_rst === 1'b1, "R3 pin asserts at once", int'(core_rst), 1);
        chk(outputs_en === 1'b0, "R9 outputs off in pin reset", int'(outputs_en), 0);
        chk(ctrl_q === 8'h00, "R3 pin clears ctrl", int'(ctrl_q), 0);
        step(3);
        rst_pin_n = 1'b1;
        @(negedge clk);
        chk(cfg_load === 1'b0, "R3 no load after 1 edge", int'(cfg_load), 0);
        @(negedge clk);
        chk(cfg_load === 1'b0, "R3 no load after 2 edges", int'(cfg_load), 0);
        @(negedge clk);
        chk(cfg_load === 1'b1, "R3 load at third edge", int'(cfg_load), 1);
        chk(cfg_from_nv === sel, "R1 pin source", int'(cfg_from_nv), int'(sel));
        time_resume(exp, "R4", 1'b1);
    endtask

    task automatic t_swr();
        store_sel = 1'b0;
        wr_ctrl(8'hA5);
        chk(ctrl_q === 8'hA5, "R5 request written", int'(ctrl_q), 'hA5);
        @(negedge clk);
        chk(core_rst === 1'b1, "R5 software reset asserts", int'(core_rst), 1);
        chk(sync_req === 1'b0, "R9 no sync for software reset", int'(sync_req), 0);
        step(4);
        chk(core_rst === 1'b1, "R7 held until tick", int'(core_rst), 1);
        chk(ctrl_q === 8'hA5, "R7 bits stay until tick", int'(ctrl_q), 'hA5);
        tick();
        chk(ctrl_q === 8'h81, "R6 other bits kept", int'(ctrl_q), 'h81);
        await_load("R5 load after software reset");
        chk(cfg_from_nv === 1'b0, "R1 software source", int'(cfg_from_nv), 0);
        time_resume(TF, "R5", 1'b0);
    endtask

    task automatic t_single_bit();
        wr_ctrl(8'h04);
        step(3);
        chk(ctrl_q === 8'h04, "R6 single bit 2 stored", int'(ctrl_q), 'h04);
        chk(core_rst === 1'b0 && outputs_en === 1'b1, "R6 single bit 2 no reset",
            int'(outputs_en), 1);
        wr_ctrl(8'h20);
        step(3);
        chk(ctrl_q === 8'h20, "R6 single bit 5 stored", int'(ctrl_q), 'h20);
        chk(core_rst === 1'b0 && outputs_en === 1'b1, "R6 single bit 5 no reset",
            int'(outputs_en), 1);
    endtask

    task automatic t_nvf_ignored();
        store_sel = 1'b1;
        wr_nvf(1'b1);
        step(3);
        chk(nvf_q === 1'b0, "R8 reload bit ignored", int'(nvf_q), 0);
        chk(core_rst === 1'b0 && outputs_en === 1'b1, "R8 no reset when ignored",
            int'(outputs_en), 1);
        store_sel = 1'b0;
    endtask

    task automatic t_nvf();
        store_sel = 1'b0;
        wr_nvf(1'b1);
        chk(nvf_q === 1'b1, "R8 reload bit set", int'(nvf_q), 1);
        @(negedge clk);
        chk(core_rst === 1'b1, "R8 reload holds core", int'(core_rst), 1);
        step(2);
        chk(core_rst === 1'b1, "R8 held until tick", int'(core_rst), 1);
        tick();
        chk(nvf_q === 1'b0, "R8 reload bit clears", int'(nvf_q), 0);
        await_load("R8 load after reload");
        chk(cfg_from_nv === 1'b1, "R1 reload uses storage", int'(cfg_from_nv), 1);
        time_resume(TN, "R8", 1'b0);
    endtask

    task automatic t_restart();
        store_sel = 1'b0;
        rst_pin_n = 1'b0;
        step(2);
        rst_pin_n = 1'b1;
        await_load("R10 first load");
        step(5);
        chk(outputs_en === 1'b0, "R10 still waiting", int'(outputs_en), 0);
        wr_ctrl(8'h24);
        @(negedge clk);
        chk(core_rst === 1'b1, "R10 reset re-entered", int'(core_rst), 1);
        tick();
        await_load("R10 second load");
        time_resume(TF, "R10", 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_por_release();
        t_pin(1'b0, TF);
        t_pin(1'b1, TN);
        t_swr();
        t_single_bit();
        t_nvf_ignored();
        t_nvf();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule